// File: doc/BRIEF.md
# Banked Control Store Address Selector

This block keeps the number of the control-store bank that the emulator microcode is running in, and turns it into registered one-hot selects for a microcode store assembled from four equal quadrants. Microcode changes bank with a dedicated load strobe that copies the low bits of the Y bus into the bank register. A boot processor can clear the register at any time through an asynchronous reset, and it can read the full bank number back on a dedicated port.

Selection depends on the task. The block looks at the task that runs next. Every I/O task is steered to quadrant 0, whatever the register holds, so all I/O microcode can stay in bank 0. The emulator (task 0) follows the register. So does the reserved loader slot (task 6), through which the boot processor writes microcode into the store, which lets the upper banks be filled. Traps and faults get no special handling: the selected bank is unchanged, so handlers must be present in every bank in use.

Top module: `csBankSelect`

## Requirements
- R1: On a rising clock edge with `bankLoadStb` high, the bank register takes the value on `yBus`. On an edge with the strobe low, the register keeps its value.
- R2: While `rstN` is low, the bank register is 0 and `quadSel` is 4'b0001, with no clock edge needed.
- R3: `quadSel` always has exactly one bit set. Bit i set means quadrant i is selected.
- R4: `quadSel` is registered. The value after an edge depends on the `nextTask` value and the bank register value present before that edge, so a newly loaded bank first reaches `quadSel` one edge after the load.
- R5: When `nextTask` is 1, 2, 3, 4, 5 or 7 before an edge, `quadSel` is 4'b0001 after that edge, whatever the bank register holds.
- R6: When `nextTask` is 0 or 6 before an edge, `quadSel` after that edge has the bit set whose index equals bank register bits [1:0].
- R7: `bankRd` shows all four bank register bits, including bits [3:2], which do not affect `quadSel`.
- R8: If `rstN` is low at an edge where `bankLoadStb` is high, the bank register stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock |
| rstN | input | 1 | Asynchronous active-low reset from the boot processor |
| bankLoadStb | input | 1 | Bank-load microinstruction strobe |
| yBus | input | 4 | Low bits of the Y bus, the new bank number |
| nextTask | input | 3 | Task that runs in the next cycle |
| quadSel | output | 4 | Registered one-hot quadrant select |
| bankRd | output | 4 | Bank register readback for the boot processor |

## Verification
The bench loads a bank and checks that `quadSel` moves one edge after the register does. A design that decoded the select combinationally, or from the incoming Y value, would switch a cycle early. It sweeps all eight task numbers against a nonzero bank. A design that mixed up the loader slot and the I/O tasks would fetch the loader's writes from bank 0, or run I/O microcode from the wrong quadrant. It loads values with the upper bits set, so a readback that dropped or decoded those bits would miscompare. It pulls reset low in the middle of a cycle, both alone and while a load strobe is pending, to catch a synchronous reset or a load that wins over the reset.

// File: rtl/csBankPkg.sv
package csBankPkg;

  // Strobes passed from the control module to the datapath
  typedef struct packed {
    logic loadBank;   // copy the Y-bus value into the bank register
    logic useBank;    // next task follows the bank register
  } bankCtlT;

endpackage

// File: rtl/csBankCtl.sv
module csBankCtl
  import csBankPkg::*;
#(
  parameter int TASK_W      = 3,
  parameter int EMU_TASK    = 0,
  parameter int LOADER_TASK = 6
) (
  input  logic              bankLoadStb,
  input  logic [TASK_W-1:0] nextTask,
  output bankCtlT           ctl
);

  localparam logic [TASK_W-1:0] EmuId    = TASK_W'(EMU_TASK);
  localparam logic [TASK_W-1:0] LoaderId = TASK_W'(LOADER_TASK);

  logic bankedTask;

  // Only the emulator and the loader slot follow the register;
  // every other task is treated as I/O and coerced to quadrant 0.
  always_comb begin
    bankedTask = (nextTask == EmuId) || (nextTask == LoaderId);
    ctl.loadBank = bankLoadStb;
    ctl.useBank  = bankedTask;
  end

endmodule

// File: rtl/csBankDp.sv
module csBankDp
  import csBankPkg::*;
#(
  parameter int BANK_W = 4,
  parameter int QUADS  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  bankCtlT           ctl,
  input  logic [BANK_W-1:0] yBus,
  output logic [QUADS-1:0]  quadSel,
  output logic [BANK_W-1:0] bankRd
);

  localparam int SEL_W = $clog2(QUADS);

  logic [BANK_W-1:0] bankReg;
  logic [SEL_W-1:0]  quadIdx;
  logic [QUADS-1:0]  quadDec;
  logic [QUADS-1:0]  quadNext;
  logic [QUADS-1:0]  quadReg;

  // Bank register: async clear wins over a simultaneous load
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      bankReg <= '0;
    else if (ctl.loadBank)
      bankReg <= yBus;
  end

  assign quadIdx = bankReg[SEL_W-1:0];

  // One-hot decode of the quadrant index
  for (genvar q = 0; q < QUADS; q++) begin : g_dec
    assign quadDec[q] = (quadIdx == SEL_W'(q));
  end

  // I/O tasks are forced to quadrant 0
  always_comb begin
    if (ctl.useBank)
      quadNext = quadDec;
    else
      quadNext = QUADS'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      quadReg <= QUADS'(1);
    else
      quadReg <= quadNext;
  end

  assign quadSel = quadReg;
  assign bankRd  = bankReg;

endmodule

// File: rtl/csBankSelect.sv
module csBankSelect
  import csBankPkg::*;
#(
  parameter int BANK_W      = 4,
  parameter int QUADS       = 4,
  parameter int TASK_W      = 3,
  parameter int EMU_TASK    = 0,
  parameter int LOADER_TASK = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bankLoadStb,
  input  logic [BANK_W-1:0] yBus,
  input  logic [TASK_W-1:0] nextTask,
  output logic [QUADS-1:0]  quadSel,
  output logic [BANK_W-1:0] bankRd
);

  bankCtlT ctl;

  csBankCtl #(
    .TASK_W(TASK_W), .EMU_TASK(EMU_TASK), .LOADER_TASK(LOADER_TASK)
  ) ctl_i (
    .bankLoadStb(bankLoadStb),
    .nextTask(nextTask),
    .ctl(ctl)
  );

  csBankDp #(
    .BANK_W(BANK_W), .QUADS(QUADS)
  ) dp_i (
    .clk(clk),
    .rstN(rstN),
    .ctl(ctl),
    .yBus(yBus),
    .quadSel(quadSel),
    .bankRd(bankRd)
  );

endmodule

// File: rtl/csBankSelect_chk.sv
module csBankSelect_chk #(
  parameter int BANK_W = 4,
  parameter int QUADS  = 4,
  parameter int TASK_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              bankLoadStb,
  input logic [BANK_W-1:0] yBus,
  input logic [TASK_W-1:0] nextTask,
  input logic [QUADS-1:0]  quadSel,
  input logic [BANK_W-1:0] bankRd
);

  localparam int SEL_W = $clog2(QUADS);

  AST_BANK_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    bankLoadStb |=> bankRd == $past(yBus)); // R1

  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !bankLoadStb |=> $stable(bankRd)); // R1

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $countones(quadSel) == 1); // R3

  AST_IO_COERCE: assert property (@(posedge clk) disable iff (!rstN)
    (nextTask != 3'd0 && nextTask != 3'd6) |=> quadSel == QUADS'(1)); // R5

  AST_BANKED_SEL: assert property (@(posedge clk) disable iff (!rstN)
    (nextTask == 3'd0 || nextTask == 3'd6)
      |=> quadSel == (QUADS'(1) << $past(bankRd[SEL_W-1:0]))); // R6

endmodule

bind csBankSelect csBankSelect_chk #(
  .BANK_W(BANK_W), .QUADS(QUADS), .TASK_W(TASK_W)
) chk_i (
  .clk(clk),
  .rstN(rstN),
  .bankLoadStb(bankLoadStb),
  .yBus(yBus),
  .nextTask(nextTask),
  .quadSel(quadSel),
  .bankRd(bankRd)
);

// File: tb/csBankSelect_tb_top.sv
`timescale 1ns/1ps
module csBankSelect_tb_top;

  logic       clk = 1'b0;
  logic       rstN;
  logic       bankLoadStb;
  logic [3:0] yBus;
  logic [2:0] nextTask;
  logic [3:0] quadSel;
  logic [3:0] bankRd;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  csBankSelect dut_i (
    .clk(clk), .rstN(rstN), .bankLoadStb(bankLoadStb), .yBus(yBus),
    .nextTask(nextTask), .quadSel(quadSel), .bankRd(bankRd)
  );

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // Drive at the falling edge, let one rising edge pass, sample 2 ns after it
  task automatic step(input logic stb, input logic [3:0] y, input logic [2:0] t);
    @(negedge clk);
    bankLoadStb = stb;
    yBus        = y;
    nextTask    = t;
    @(posedge clk);
    #2;
  endtask

  function automatic logic [3:0] oneHot(input logic [1:0] i);
    return 4'b0001 << i;
  endfunction

  task automatic tResetState();
    check("R2 bank after reset", bankRd, 4'h0);
    check("R2 select after reset", quadSel, 4'b0001);
  endtask

  task automatic tLoadAndLatency();
    step(1'b1, 4'h5, 3'd0);               // load 5; select still reflects bank 0
    check("R1 bank loaded", bankRd, 4'h5);
    check("R7 readback all bits", bankRd, 4'h5);
    check("R4 select lags load by one edge", quadSel, 4'b0001);
    step(1'b0, 4'hA, 3'd0);               // strobe low: Y must not be taken
    check("R1 bank held", bankRd, 4'h5);
    check("R6 emulator follows bank", quadSel, oneHot(2'd1));
  endtask

  task automatic tTaskSweep();
    step(1'b1, 4'hE, 3'd0);               // bank 14 -> quadrant 2
    check("R7 upper bits visible", bankRd, 4'hE);
    for (int t = 0; t < 8; t++) begin
      step(1'b0, 4'h0, 3'(t));
      if (t == 0 || t == 6)
        check("R6 banked task select", quadSel, oneHot(2'd2));
      else
        check("R5 io task coerced", quadSel, 4'b0001);
      check("R5 bank untouched by task", bankRd, 4'hE);
    end
  endtask

  task automatic tAllQuadrants();
    for (int b = 0; b < 4; b++) begin
      step(1'b1, 4'(b + 8), 3'd6);
      step(1'b0, 4'h0, 3'd6);
      check("R3 quadrant decode", quadSel, oneHot(2'(b)));
    end
  endtask

  task automatic tIoThenBack();
    step(1'b1, 4'h3, 3'd2);               // load during I/O task
    check("R5 select forced during io", quadSel, 4'b0001);
    step(1'b0, 4'h0, 3'd7);
    check("R5 io task 7 coerced", quadSel, 4'b0001);
    step(1'b0, 4'h0, 3'd0);
    check("R6 returns to bank", quadSel, oneHot(2'd3));
  endtask

  task automatic tAsyncReset();
    @(negedge clk);
    bankLoadStb = 1'b0;
    nextTask    = 3'd0;
    #3 rstN = 1'b0;
    #1;
    check("R2 async clear bank", bankRd, 4'h0);
    check("R2 async clear select", quadSel, 4'b0001);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic tResetBeatsLoad();
    step(1'b1, 4'h9, 3'd0);
    check("R1 bank before race", bankRd, 4'h9);
    @(negedge clk);
    bankLoadStb = 1'b1;
    yBus        = 4'h7;
    rstN        = 1'b0;
    @(posedge clk);
    #2;
    check("R8 reset wins over load", bankRd, 4'h0);
    check("R8 select held at 0", quadSel, 4'b0001);
    @(negedge clk);
    bankLoadStb = 1'b0;
    rstN        = 1'b1;
    step(1'b0, 4'h0, 3'd0);
    check("R8 bank stays 0 after release", bankRd, 4'h0);
  endtask

  initial begin
    rstN        = 1'b0;
    bankLoadStb = 1'b0;
    yBus        = 4'h0;
    nextTask    = 3'd0;
    repeat (3) @(posedge clk);
    #2;
    tResetState();
    @(negedge clk);
    rstN = 1'b1;
    tLoadAndLatency();
    tTaskSweep();
    tAllQuadrants();
    tIoThenBack();
    tAsyncReset();
    tResetBeatsLoad();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        nChecks++;
        nFails++;
        $display("FAIL watchdog: actual running expected finished");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule